// File: doc/BRIEF.md
# Power-On Strap Capture and Pin Turnaround

This block reads four dual-purpose pads while the power-on reset is held and stores their levels in a 4-bit latch. It then turns the same pads into clock outputs. Each pad has a weak pull-up, so a pad with no strap resistor reads as 1. The stored code is decoded into a 3-bit CPU frequency index, which feeds the PLL outside this block, and a bus mode bit. When the bus mode bit is 1, the bus clocks run at half the CPU rate. When it is 0, they run at a fixed asynchronous rate.

One frequency code is reserved for production test. In that mode every generated clock is a plain division of the reference clock: CPU and 48 MHz at half the reference, 24 MHz at a quarter, and the bus clock at a quarter (bus mode 1) or a third (bus mode 0). A small sequencer controls the pad turnaround with three named states:
- `ST_HOLD` is entered asynchronously while reset is low. Its transition *strap_capture* loads the latch on the first reference edge with reset high.
- `ST_ARM` holds the pads still undriven. Its transition *turnaround* leads to the next state one edge later.
- `ST_DRIVE` enables the pad drivers until the next power-on reset.

Top module: `strap_cfg_latch`

## Requirements
- R1: While `por_n` is low, `pad_oe` and `pad_out` are 0, all test clocks are 0, `test_mode` is 0, and the decoded outputs show the all-pull-up code: `fs_sel`=3'b111 and `bus_sync`=1.
- R2: On the first rising `clk_ref` edge with `por_n` high, `pad_in` is captured. After that edge, `fs_sel` equals `pad_in[3:1]` (bit 3 = FS2, bit 2 = FS1, bit 1 = FS0) and `bus_sync` equals `pad_in[0]`.
- R3: After capture, the decoded outputs do not change, whatever `pad_in` does, until `por_n` falls again.
- R4: `pad_oe` stays 4'b0000 through reset and through the capture edge. It becomes 4'b1111 on the second rising edge after release and stays there.
- R5: `test_mode` is 1 from the second edge after release exactly when the captured `fs_sel` is 3'b011. Otherwise it is 0.
- R6: In test mode, `cpu_tst` and `clk48_tst` are the reference divided by 2, and `clk24_tst` is the reference divided by 4. All dividers leave zero together. With n = edges since the second post-release edge, the divide-by-2 output is n mod 2 and the divide-by-4 output is 1 when n mod 4 is at least 2.
- R7: In test mode, `bus_tst` equals the divide-by-4 clock when `bus_sync` is 1. When `bus_sync` is 0, it is high only when n mod 3 = 2, so it is one period high and two low.
- R8: Outside test mode, all four test clocks stay 0.
- R9: While enabled, `pad_out[0]` carries `clk_ref`. `pad_out[3:1]` carry `cpu_tst` in test mode and `pll_cpu_clk` otherwise.
- R10: A new low pulse on `por_n` restarts the sequence, and a different strap code is then captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| pad_in | input | 4 | Pad levels: [0] bus mode strap, [3:1] FS2..FS0 |
| pll_cpu_clk | input | 1 | CPU clock from the PLL for normal operation |
| pad_oe | output | 4 | Pad driver enables |
| pad_out | output | 4 | Clock driven onto each pad |
| fs_sel | output | 3 | Latched CPU frequency index |
| bus_sync | output | 1 | 1 = bus clock is half the CPU clock, 0 = fixed rate |
| test_mode | output | 1 | Production test code active |
| cpu_tst | output | 1 | Test-mode CPU clock |
| clk48_tst | output | 1 | Test-mode 48 MHz output |
| clk24_tst | output | 1 | Test-mode 24 MHz output |
| bus_tst | output | 1 | Test-mode bus clock |

## Verification
The bench uses five strap patterns:
- The test code with bus mode 0 distinguishes the divide-by-3 bus path.
- The test code with bus mode 1 distinguishes the divide-by-4 bus path.
- Two normal codes that differ only in the bus bit show that the test clocks stay quiet and the PLL clock reaches the pads.
- The all-ones unstrapped code equals the reset default, so it can only pass if capture and turnaround timing are right.

In every run, `pad_in` is scrambled after capture to separate a true latch from a transparent path. A mid-run reset pulse then shows that the sequence restarts cleanly with a new code.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
    localparam int STRAP_N  = 4;
    localparam int FS_W     = 3;
    localparam int BUS_BIT  = 0;
    localparam logic [FS_W-1:0] TEST_CODE = 3'b011;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_ARM   = 2'd1,
        ST_DRIVE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/strap_seq.sv
module strap_seq
    import strap_cfg_pkg::*;
#(
    parameter int N = STRAP_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pad_in,
    output logic [N-1:0] latch_o,
    output logic         captured_o,
    output logic         drive_o
);
    seq_state_e state_q, state_d;
    logic [N-1:0] latch_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  state_d = ST_ARM;
            ST_ARM:   state_d = ST_DRIVE;
            ST_DRIVE: state_d = ST_DRIVE;
            default:  state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            latch_q <= '1;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HOLD)
                latch_q <= pad_in;
        end
    end

    always_comb begin
        captured_o = 1'b0;
        drive_o    = 1'b0;
        unique case (state_q)
            ST_HOLD:  ;
            ST_ARM:   captured_o = 1'b1;
            ST_DRIVE: begin captured_o = 1'b1; drive_o = 1'b1; end
            default:  ;
        endcase
    end

    assign latch_o = latch_q;

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (captured_o && $past(captured_o)) |-> $stable(latch_q));
endmodule

// File: rtl/strap_decode.sv
module strap_decode
    import strap_cfg_pkg::*;
#(
    parameter int N = STRAP_N,
    parameter int W = FS_W
) (
    input  logic [N-1:0] latch_i,
    output logic [W-1:0] fs_sel_o,
    output logic         bus_sync_o,
    output logic         test_code_o
);
    assign fs_sel_o    = latch_i[W:1];
    assign bus_sync_o  = latch_i[BUS_BIT];
    assign test_code_o = (latch_i[W:1] == TEST_CODE);
endmodule

// File: rtl/test_clk_div.sv
module test_clk_div (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic div2_o,
    output logic div3_o,
    output logic div4_o
);
    logic       t2_q;
    logic [1:0] c4_q;
    logic [1:0] c3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t2_q <= 1'b0;
            c4_q <= '0;
            c3_q <= '0;
        end else if (run) begin
            t2_q <= ~t2_q;
            c4_q <= c4_q + 2'd1;
            c3_q <= (c3_q == 2'd2) ? 2'd0 : c3_q + 2'd1;
        end
    end

    assign div2_o = t2_q;
    assign div4_o = c4_q[1];
    assign div3_o = (c3_q == 2'd2);

    // R7
    div3_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div3_o |=> !div3_o);
    // R6
    div2_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (div2_o != $past(div2_o)));
endmodule

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch
    import strap_cfg_pkg::*;
#(
    parameter int N = STRAP_N,
    parameter int W = FS_W
) (
    input  logic         clk_ref,
    input  logic         por_n,
    input  logic [N-1:0] pad_in,
    input  logic         pll_cpu_clk,
    output logic [N-1:0] pad_oe,
    output logic [N-1:0] pad_out,
    output logic [W-1:0] fs_sel,
    output logic         bus_sync,
    output logic         test_mode,
    output logic         cpu_tst,
    output logic         clk48_tst,
    output logic         clk24_tst,
    output logic         bus_tst
);
    logic [N-1:0] latch_w;
    logic captured_w, drive_w, test_code_w;
    logic d2_w, d3_w, d4_w;

    strap_seq #(.N(N)) u_seq (
        .clk(clk_ref), .rst_n(por_n), .pad_in(pad_in),
        .latch_o(latch_w), .captured_o(captured_w), .drive_o(drive_w)
    );

    strap_decode #(.N(N), .W(W)) u_dec (
        .latch_i(latch_w), .fs_sel_o(fs_sel),
        .bus_sync_o(bus_sync), .test_code_o(test_code_w)
    );

    assign test_mode = drive_w & test_code_w;

    test_clk_div u_div (
        .clk(clk_ref), .rst_n(por_n), .run(test_mode),
        .div2_o(d2_w), .div3_o(d3_w), .div4_o(d4_w)
    );

    always_comb begin
        cpu_tst   = test_mode & d2_w;
        clk48_tst = test_mode & d2_w;
        clk24_tst = test_mode & d4_w;
        bus_tst   = test_mode & (bus_sync ? d4_w : d3_w);
    end

    assign pad_oe = {N{drive_w}};

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_pad
            if (g == BUS_BIT) begin : g_ref
                assign pad_out[g] = pad_oe[g] & clk_ref;
            end else begin : g_cpu
                assign pad_out[g] = pad_oe[g] & (test_mode ? cpu_tst : pll_cpu_clk);
            end
        end
    endgenerate

    // R4
    oe_after_capture_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        $rose(pad_oe[0]) |-> $past(captured_w));
    // R8
    test_clk_quiet_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        !test_mode |-> !(cpu_tst | clk48_tst | clk24_tst | bus_tst));
    // R5
    test_needs_drive_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        test_mode |-> (pad_oe == {N{1'b1}}));
endmodule

// File: tb/strap_cfg_latch_bench.sv
`timescale 1ns/1ps
module strap_cfg_latch_bench;
    logic clk_ref = 1'b0;
    logic por_n = 1'b0;
    logic [3:0] pad_in = 4'b0000;
    logic pll_cpu_clk = 1'b0;
    logic [3:0] pad_oe, pad_out;
    logic [2:0] fs_sel;
    logic bus_sync, test_mode, cpu_tst, clk48_tst, clk24_tst, bus_tst;

    int n_cmp = 0;
    int n_bad = 0;
    int k = 0;
    logic [3:0] cap = 4'hF;
    int cyc = 0;

    always #5 clk_ref = ~clk_ref;

    strap_cfg_latch u_strap_cfg_latch (
        .clk_ref(clk_ref), .por_n(por_n), .pad_in(pad_in), .pll_cpu_clk(pll_cpu_clk),
        .pad_oe(pad_oe), .pad_out(pad_out), .fs_sel(fs_sel), .bus_sync(bus_sync),
        .test_mode(test_mode), .cpu_tst(cpu_tst), .clk48_tst(clk48_tst),
        .clk24_tst(clk24_tst), .bus_tst(bus_tst)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural model state
    always @(posedge clk_ref) begin
        cyc <= cyc + 1;
        if (!por_n) k <= 0;
        else begin
            if (k == 0) cap <= pad_in;
            k <= k + 1;
        end
    end

    // compare every clock, 2 ns after the edge
    always @(posedge clk_ref) begin
        #2;
        begin
            automatic int ef = (k >= 1) ? int'(cap[3:1]) : 7;
            automatic int eb = (k >= 1) ? int'(cap[0]) : 1;
            automatic int eoe = (k >= 2) ? 15 : 0;
            automatic int etm = (k >= 2 && cap[3:1] == 3'b011) ? 1 : 0;
            automatic int n = (k >= 2) ? k - 2 : 0;
            automatic int e2 = etm & (n % 2);
            automatic int e4 = etm & ((n % 4) >= 2 ? 1 : 0);
            automatic int e3 = etm & ((n % 3) == 2 ? 1 : 0);
            automatic int ebus = (eb == 1) ? e4 : e3;
            automatic int ecpu = (eoe != 0) ? (etm ? e2 : int'(pll_cpu_clk)) : 0;
            automatic int epo = (eoe != 0) ? (ecpu * 14 + 1) : 0;
            chk((k >= 1) ? "R2/R3 fs_sel" : "R1 fs_sel", fs_sel, ef);
            chk((k >= 1) ? "R2/R3 bus_sync" : "R1 bus_sync", bus_sync, eb);
            chk("R4 pad_oe", pad_oe, eoe);
            chk("R5 test_mode", test_mode, etm);
            chk("R6 cpu_tst", cpu_tst, e2);
            chk("R6 clk48_tst", clk48_tst, e2);
            chk("R6 clk24_tst", clk24_tst, e4);
            chk(etm ? "R7 bus_tst" : "R8 bus_tst", bus_tst, ebus);
            chk("R9 pad_out", pad_out, epo);
        end
    end

    task automatic run_code(input logic [3:0] code, input int cycles);
        @(negedge clk_ref);
        por_n = 1'b0;
        pad_in = code;
        repeat (4) @(negedge clk_ref);
        por_n = 1'b1;
        @(negedge clk_ref);
        for (int i = 0; i < cycles; i++) begin
            pad_in = ~pad_in ^ 4'(i);          // R3: scramble after capture
            if (i % 3 == 0) pll_cpu_clk = ~pll_cpu_clk;
            @(negedge clk_ref);
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        run_code(4'b0110, 40);   // R7 test, bus mode 0 -> div3
        run_code(4'b0111, 40);   // R7 test, bus mode 1 -> div4
        run_code(4'b0101, 30);   // R8 normal, fs 010 sync
        run_code(4'b0100, 30);   // R8 normal, fs 010 async
        run_code(4'b1111, 30);   // R2 unstrapped default
        // R10: short reset pulse mid-run, then new code
        @(negedge clk_ref);
        por_n = 1'b0; pad_in = 4'b0110;
        @(negedge clk_ref);
        por_n = 1'b1;
        repeat (20) @(negedge clk_ref);
        @(negedge clk_ref);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule